// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block paints or moves rectangular pixel regions inside a local frame-buffer memory. Software programs the operands through a small 32-bit register file: source and destination start points, rectangle size, row pitch, foreground colour, pixel size and the two base addresses. It then writes the control word with the go bit set. The engine checks the request. It then walks the rectangle row by row over a synchronous single-port memory and lowers its busy flag when the last pixel has been written.

A fill writes the foreground colour into every destination pixel, one write per cycle. A copy moves every pixel with a read followed by a write, so each pixel takes two cycles. A direction bit makes both walks start at the given point and step towards lower coordinates. With that bit, an overlapping copy can be ordered so that no source pixel is overwritten before it is read. Pixels are 1, 2 or 4 bytes wide. Byte enables and replicated write data place each pixel in its lanes of the 32-bit memory word.

Top module: `blit2d_engine`

## Requirements
- R1: Registers are selected by word index on `reg_addr_i`: 0 control, 1 source point, 2 destination point, 3 size, 4 pitch (pixels, bits 12:0), 5 foreground, 6 format, 7 source base, 8 destination base. Each reads back what was last written, except that control bits 31:29 read as go=0, busy (bit 30) and error (bit 29). Unmapped indices read 0.
- R2: A control write with bit 31 set starts the operation selected by bits 20:16 (0 copy, 1 fill). `busy_o` rises in the cycle after the write, and bit 31 always reads back as 0.
- R3: Fill writes the foreground colour, truncated to the pixel size, to every destination pixel. It makes exactly one memory write per cycle, and `busy_o` is high for width*height cycles.
- R4: Copy reads each source pixel and writes it to the matching destination pixel in the next cycle. `busy_o` is high for 2*width*height cycles.
- R5: Format register bits 21:20 select 1, 2 or 4 bytes per pixel for values 0, 1 and 2. Byte enables select the lanes given by the low address bits (little-endian lanes), and no other byte in the word changes.
- R6: A pixel's byte address is base[25:0] + (y*pitch + x)*bytes_per_pixel. Points hold x in bits 28:16 and y in bits 15:0, and the size register holds width in 28:16 and height in 15:0. Rows form the outer loop and columns the inner loop.
- R7: With control bit 27 set, the pixel at row r and column c uses (x0-c, y0-r) instead of (x0+c, y0+r).
- R8: A go write is rejected if any of these holds: the opcode is above 1, the format is 3, the addressing field (format register bits 19:16) is not 0, or bit 27 of either base is set. A rejected go sets error bit 29 and makes no memory access. The next accepted go clears the error bit.
- R9: While `busy_o` is high, every register write, including a go, is ignored.
- R10: A go with zero width or zero height makes no memory access, and `busy_o` stays low.
- R11: After reset, all registers read 0, `busy_o` is low and `mem_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 26 | Byte address |
| mem_be_o | output | 4 | Byte-lane enables for writes |
| mem_wdata_o | output | 32 | Pixel replicated across lanes |
| mem_rdata_i | input | 32 | Read word, valid the cycle after a read request |

## Verification
The assertions assume the memory returns read data exactly one cycle after a read request. They also assume software issues a go only while the engine is idle or accepts that such a go is dropped. The lane checks assume base addresses aligned to the pixel size and pitches that keep every pixel inside one word. The stimulus uses aligned bases, a pitch of 16 pixels and rectangles that stay inside a 1 KiB model memory. Reverse walks always start far enough from zero that no coordinate wraps.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;
  localparam logic [3:0] RG_CTRL  = 4'd0;
  localparam logic [3:0] RG_SRC   = 4'd1;
  localparam logic [3:0] RG_DST   = 4'd2;
  localparam logic [3:0] RG_DIM   = 4'd3;
  localparam logic [3:0] RG_PITCH = 4'd4;
  localparam logic [3:0] RG_FG    = 4'd5;
  localparam logic [3:0] RG_FMT   = 4'd6;
  localparam logic [3:0] RG_SBASE = 4'd7;
  localparam logic [3:0] RG_DBASE = 4'd8;
  localparam int unsigned NUM_REGS = 9;

  localparam int unsigned CTL_GO   = 31;
  localparam int unsigned CTL_BUSY = 30;
  localparam int unsigned CTL_ERR  = 29;
  localparam int unsigned CTL_REV  = 27;
  localparam int unsigned BASE_EXT = 27;

  localparam logic [4:0] OP_COPY = 5'd0;
  localparam logic [4:0] OP_FILL = 5'd1;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_FILL = 2'd1,
    WK_RD   = 2'd2,
    WK_WR   = 2'd3
  } walk_st_e;
endpackage

// File: rtl/blit2d_regs.sv
module blit2d_regs
  import blit2d_pkg::*;
#(
  parameter int unsigned AW = 26,
  parameter int unsigned XW = 13,
  parameter int unsigned YW = 16,
  parameter int unsigned PW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [3:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  output logic          launch_o,
  output logic [4:0]    op_o,
  output logic          rev_o,
  output logic [XW-1:0] sx_o,
  output logic [YW-1:0] sy_o,
  output logic [XW-1:0] dx_o,
  output logic [YW-1:0] dy_o,
  output logic [XW-1:0] w_o,
  output logic [YW-1:0] h_o,
  output logic [PW-1:0] pitch_o,
  output logic [31:0]   fg_o,
  output logic [1:0]    fmt_o,
  output logic [AW-1:0] sbase_o,
  output logic [AW-1:0] dbase_o
);
  logic [31:0] r_q [NUM_REGS];
  logic        err_q;
  logic        wr_ok, go, bad;

  assign wr_ok = wr_i && !busy_i && (addr_i < 4'(NUM_REGS));
  assign go    = wr_ok && (addr_i == RG_CTRL) && wdata_i[CTL_GO];
  // R8: request validated against the opcode being written and the stored operands
  assign bad   = (wdata_i[20:16] > OP_FILL) || (r_q[RG_FMT][21:20] == 2'd3) ||
                 (r_q[RG_FMT][19:16] != 4'd0) || r_q[RG_SBASE][BASE_EXT] ||
                 r_q[RG_DBASE][BASE_EXT];
  assign launch_o = go && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_REGS); i++) r_q[i] <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_ok) r_q[addr_i] <= (addr_i == RG_CTRL) ? (wdata_i & 32'h1FFF_FFFF) : wdata_i;
      if (go) err_q <= bad;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == RG_CTRL)
      rdata_o = r_q[RG_CTRL] | {1'b0, busy_i, err_q, 29'd0};
    else if (addr_i < 4'(NUM_REGS))
      rdata_o = r_q[addr_i];
  end

  assign op_o    = r_q[RG_CTRL][20:16];
  assign rev_o   = r_q[RG_CTRL][CTL_REV];
  assign sx_o    = r_q[RG_SRC][16 +: XW];
  assign sy_o    = r_q[RG_SRC][YW-1:0];
  assign dx_o    = r_q[RG_DST][16 +: XW];
  assign dy_o    = r_q[RG_DST][YW-1:0];
  assign w_o     = r_q[RG_DIM][16 +: XW];
  assign h_o     = r_q[RG_DIM][YW-1:0];
  assign pitch_o = r_q[RG_PITCH][PW-1:0];
  assign fg_o    = r_q[RG_FG];
  assign fmt_o   = r_q[RG_FMT][21:20];
  assign sbase_o = r_q[RG_SBASE][AW-1:0];
  assign dbase_o = r_q[RG_DBASE][AW-1:0];
endmodule

// File: rtl/blit2d_walk.sv
module blit2d_walk
  import blit2d_pkg::*;
#(
  parameter int unsigned XW = 13,
  parameter int unsigned YW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          copy_i,
  input  logic [XW-1:0] w_i,
  input  logic [YW-1:0] h_i,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o,
  output logic          busy_o,
  output logic          req_o,
  output logic          we_o
);
  walk_st_e      st_q;
  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;
  logic          last_col, last_row;

  assign last_col = (col_q == w_i - 1'b1);
  assign last_row = (row_q == h_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WK_IDLE;
      col_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        WK_IDLE: if (launch_i && (w_i != '0) && (h_i != '0)) begin  // R10
          st_q  <= copy_i ? WK_RD : WK_FILL;
          col_q <= '0;
          row_q <= '0;
        end
        WK_RD: st_q <= WK_WR;
        WK_FILL, WK_WR: begin
          if (st_q == WK_WR) st_q <= WK_RD;
          if (last_col) begin
            col_q <= '0;
            if (last_row) st_q <= WK_IDLE;
            else row_q <= row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign col_o  = col_q;
  assign row_o  = row_q;
  assign busy_o = (st_q != WK_IDLE);
  assign req_o  = (st_q != WK_IDLE);
  assign we_o   = (st_q == WK_FILL) || (st_q == WK_WR);
endmodule

// File: rtl/blit2d_addr.sv
module blit2d_addr #(
  parameter int unsigned AW = 26,
  parameter int unsigned XW = 13,
  parameter int unsigned YW = 16,
  parameter int unsigned PW = 13
) (
  input  logic [AW-1:0] base_i,
  input  logic [XW-1:0] x0_i,
  input  logic [YW-1:0] y0_i,
  input  logic [XW-1:0] col_i,
  input  logic [YW-1:0] row_i,
  input  logic          rev_i,
  input  logic [PW-1:0] pitch_i,
  input  logic [1:0]    bpp_log2_i,
  output logic [AW-1:0] addr_o
);
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [31:0]   lin, off;

  // R7: reverse walk steps down from the start point
  assign x   = rev_i ? (x0_i - col_i) : (x0_i + col_i);
  assign y   = rev_i ? (y0_i - row_i) : (y0_i + row_i);
  // R6
  assign lin = 32'(y) * 32'(pitch_i) + 32'(x);
  assign off = lin << bpp_log2_i;
  assign addr_o = base_i + off[AW-1:0];
endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine
  import blit2d_pkg::*;
#(
  parameter int unsigned AW = 26,
  parameter int unsigned XW = 13,
  parameter int unsigned YW = 16,
  parameter int unsigned PW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i
);
  localparam int unsigned NPT = 2;  // 0 source, 1 destination

  logic          launch, rev, copy;
  logic [4:0]    op;
  logic [XW-1:0] sx, dx, w, col;
  logic [YW-1:0] sy, dy, h, row;
  logic [PW-1:0] pitch;
  logic [31:0]   fg, rd_sh, pix;
  logic [1:0]    fmt;
  logic [AW-1:0] sbase, dbase;
  logic [AW-1:0] pt_addr [NPT];

  blit2d_regs #(.AW(AW), .XW(XW), .YW(YW), .PW(PW)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .busy_i(busy_o), .launch_o(launch), .op_o(op), .rev_o(rev),
    .sx_o(sx), .sy_o(sy), .dx_o(dx), .dy_o(dy), .w_o(w), .h_o(h), .pitch_o(pitch),
    .fg_o(fg), .fmt_o(fmt), .sbase_o(sbase), .dbase_o(dbase)
  );

  // op is latched at the launch edge; walker samples it only in idle
  assign copy = (launch ? reg_wdata_i[20:16] : op) == OP_COPY;

  blit2d_walk #(.XW(XW), .YW(YW)) u_walk (
    .clk_i, .rst_ni, .launch_i(launch), .copy_i(copy), .w_i(w), .h_i(h),
    .col_o(col), .row_o(row), .busy_o(busy_o), .req_o(mem_req_o), .we_o(mem_we_o)
  );

  for (genvar g = 0; g < NPT; g++) begin : g_pt
    blit2d_addr #(.AW(AW), .XW(XW), .YW(YW), .PW(PW)) u_addr (
      .base_i(g == 0 ? sbase : dbase), .x0_i(g == 0 ? sx : dx), .y0_i(g == 0 ? sy : dy),
      .col_i(col), .row_i(row), .rev_i(rev), .pitch_i(pitch), .bpp_log2_i(fmt),
      .addr_o(pt_addr[g])
    );
  end

  assign mem_addr_o = mem_we_o ? pt_addr[1] : pt_addr[0];

  // R4: source pixel taken from the lanes of the word read last cycle
  assign rd_sh = mem_rdata_i >> {pt_addr[0][1:0], 3'b000};
  assign pix   = (op == OP_COPY) ? rd_sh : fg;

  // R5: lane steering per pixel size
  always_comb begin
    unique case (fmt)
      2'd0: begin
        mem_wdata_o = {4{pix[7:0]}};
        mem_be_o    = 4'b0001 << pt_addr[1][1:0];
      end
      2'd1: begin
        mem_wdata_o = {2{pix[15:0]}};
        mem_be_o    = 4'b0011 << {pt_addr[1][1], 1'b0};
      end
      default: begin
        mem_wdata_o = pix;
        mem_be_o    = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/blit2d_engine_chk.sv
module blit2d_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [3:0] reg_addr_i,
  input logic       reg_go_i,
  input logic       rd_go_i,
  input logic       busy_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [3:0] mem_be_o
);
  // R2
  busy_from_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_wr_i && reg_addr_i == 4'd0 && reg_go_i));

  // R2
  go_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 4'd0) |-> !rd_go_i);

  // R3
  req_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R4
  copy_rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));

  // R5
  lane_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |->
      ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 || $countones(mem_be_o) == 4));
endmodule

bind blit2d_engine blit2d_engine_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_go_i(reg_wdata_i[31]), .rd_go_i(reg_rdata_o[31]), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o)
);

// File: tb/test_blit2d_engine.sv
`timescale 1ns/1ps
module test_blit2d_engine;
  localparam int MEMB  = 1024;
  localparam int PITCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, mem_req, mem_we;
  logic [25:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int checks = 0;
  int fails  = 0;
  int req_cnt = 0;
  int busy_cyc = 0;

  logic [7:0] mem_b [MEMB];
  logic [7:0] ref_b [MEMB];

  always #10 clk = ~clk;

  blit2d_engine i_blit2d_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMB; i++) mem_b[i] <= 8'(i * 7 + 3);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem_b[{mem_addr[9:2], 2'(i)}] <= mem_wdata[8*i +: 8];
      end else begin
        mem_rdata <= {mem_b[{mem_addr[9:2], 2'd3}], mem_b[{mem_addr[9:2], 2'd2}],
                      mem_b[{mem_addr[9:2], 2'd1}], mem_b[{mem_addr[9:2], 2'd0}]};
      end
    end
  end

  always @(posedge clk) begin
    if (mem_req) req_cnt <= req_cnt + 1;
    if (busy) busy_cyc <= busy_cyc + 1;
  end

  typedef struct packed {
    logic [4:0]  op;
    logic        rev;
    logic [1:0]  fmt;
    logic [12:0] sx;
    logic [15:0] sy;
    logic [12:0] dx;
    logic [15:0] dy;
    logic [12:0] w;
    logic [15:0] h;
    logic [31:0] fg;
    logic [25:0] sb;
    logic [25:0] db;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 1'b0, 2'd0, 13'd0, 16'd0, 13'd3, 16'd2, 13'd5, 16'd3, 32'h1234_5678, 26'h000, 26'h000},
    '{5'd1, 1'b0, 2'd1, 13'd0, 16'd0, 13'd1, 16'd1, 13'd3, 16'd2, 32'hABCD_BEEF, 26'h000, 26'h100},
    '{5'd1, 1'b0, 2'd2, 13'd0, 16'd0, 13'd2, 16'd0, 13'd2, 16'd2, 32'hCAFE_0001, 26'h000, 26'h200},
    '{5'd0, 1'b0, 2'd0, 13'd0, 16'd0, 13'd8, 16'd4, 13'd4, 16'd2, 32'h0,         26'h000, 26'h000},
    '{5'd0, 1'b0, 2'd1, 13'd2, 16'd1, 13'd0, 16'd5, 13'd3, 16'd2, 32'h0,         26'h100, 26'h200},
    '{5'd0, 1'b0, 2'd2, 13'd1, 16'd0, 13'd4, 16'd2, 13'd2, 16'd2, 32'h0,         26'h300, 26'h000},
    '{5'd0, 1'b1, 2'd0, 13'd7, 16'd3, 13'd8, 16'd4, 13'd4, 16'd3, 32'h0,         26'h000, 26'h000},
    '{5'd1, 1'b1, 2'd1, 13'd0, 16'd0, 13'd5, 16'd4, 13'd3, 16'd2, 32'h0000_9A5C, 26'h000, 26'h080}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic ref_apply(input vec_t v);
    int bpp;
    bpp = 1 << v.fmt;
    for (int r = 0; r < int'(v.h); r++) begin
      for (int c = 0; c < int'(v.w); c++) begin
        int sxx, syy, dxx, dyy, sa, da;
        sxx = v.rev ? int'(v.sx) - c : int'(v.sx) + c;
        syy = v.rev ? int'(v.sy) - r : int'(v.sy) + r;
        dxx = v.rev ? int'(v.dx) - c : int'(v.dx) + c;
        dyy = v.rev ? int'(v.dy) - r : int'(v.dy) + r;
        sa = (int'(v.sb) + (syy * PITCH + sxx) * bpp) & (MEMB - 1);
        da = (int'(v.db) + (dyy * PITCH + dxx) * bpp) & (MEMB - 1);
        for (int k = 0; k < bpp; k++)
          ref_b[da + k] = (v.op == 5'd0) ? ref_b[sa + k] : v.fg[8*k +: 8];
      end
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < MEMB; i++)
      if (mem_b[i] !== ref_b[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, 32'(mem_b[first]), 32'(ref_b[first]));
  endtask

  task automatic load_vec(input vec_t v);
    wr_reg(4'd1, {3'b0, v.sx, v.sy});
    wr_reg(4'd2, {3'b0, v.dx, v.dy});
    wr_reg(4'd3, {3'b0, v.w, v.h});
    wr_reg(4'd5, v.fg);
    wr_reg(4'd6, 32'(v.fmt) << 20);
    wr_reg(4'd7, 32'(v.sb));
    wr_reg(4'd8, 32'(v.db));
  endtask

  function automatic logic [31:0] go_word(input logic [4:0] op, input logic rev);
    return 32'h8000_0000 | (32'(rev) << 27) | (32'(op) << 16);
  endfunction

  task automatic try_bad(input logic [31:0] ctl, input string req);
    int r0;
    logic [31:0] d;
    r0 = req_cnt;
    wr_reg(4'd0, ctl);
    check(busy == 1'b0, req, 32'(busy), 0);
    repeat (3) @(negedge clk);
    check(req_cnt == r0, req, 32'(req_cnt - r0), 0);
    rd_reg(4'd0, d);
    check(d[29] == 1'b1, req, d, 32'h2000_0000);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int b0, r0;
    vec_t v;
    for (int i = 0; i < MEMB; i++) ref_b[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 1'b0, "R11 busy", 32'(busy), 0);
    check(mem_req == 1'b0, "R11 req", 32'(mem_req), 0);
    rd_reg(4'd0, d); check(d == 0, "R11 ctrl", d, 0);
    rd_reg(4'd5, d); check(d == 0, "R11 fg", d, 0);
    rst_n = 1'b1;

    // R1: readback and unmapped index
    wr_reg(4'd4, PITCH);
    rd_reg(4'd4, d); check(d == PITCH, "R1 pitch", d, PITCH);
    wr_reg(4'd1, 32'h0ABC_1234);
    rd_reg(4'd1, d); check(d == 32'h0ABC_1234, "R1 src", d, 32'h0ABC_1234);
    rd_reg(4'd15, d); check(d == 0, "R1 unmapped", d, 0);

    // R3 R4 R5 R6 R7: vector table
    for (int n = 0; n < NV; n++) begin
      int exp_cyc;
      v = VECS[n];
      load_vec(v);
      ref_apply(v);
      exp_cyc = int'(v.w) * int'(v.h) * ((v.op == 5'd0) ? 2 : 1);
      b0 = busy_cyc;
      wr_reg(4'd0, go_word(v.op, v.rev));
      check(busy == 1'b1, "R2 busy after go", 32'(busy), 1);
      wait_idle();
      check(busy_cyc - b0 == exp_cyc, (v.op == 5'd0) ? "R4 cycles" : "R3 cycles",
            32'(busy_cyc - b0), 32'(exp_cyc));
      cmp_mem(v.rev ? "R7 memory" : "R6 memory");
      rd_reg(4'd0, d);
      check(d[31:30] == 2'b00, "R2 go/busy readback", d, 32'(v.rev) << 27);
    end

    // R8: rejected launches
    try_bad(go_word(5'd2, 1'b0), "R8 opcode");
    wr_reg(4'd6, 32'h0030_0000);
    try_bad(go_word(5'd1, 1'b0), "R8 format");
    wr_reg(4'd6, 32'h0001_0000);
    try_bad(go_word(5'd1, 1'b0), "R8 addressing");
    wr_reg(4'd6, 32'h0);
    wr_reg(4'd7, 32'h0800_0000);
    try_bad(go_word(5'd1, 1'b0), "R8 nonlocal");
    cmp_mem("R8 memory untouched");
    wr_reg(4'd7, 32'h0);

    // R9: writes ignored while busy
    v = '{5'd1, 1'b0, 2'd0, 13'd0, 16'd0, 13'd0, 16'd8, 13'd8, 16'd4, 32'h55, 26'h0, 26'h0};
    load_vec(v);
    ref_apply(v);
    b0 = busy_cyc;
    wr_reg(4'd0, go_word(5'd1, 1'b0));
    rd_reg(4'd0, d); check(d[29] == 1'b0, "R8 error cleared", d, 0);
    wr_reg(4'd5, 32'hAA);
    wr_reg(4'd0, go_word(5'd1, 1'b0));
    wait_idle();
    check(busy_cyc - b0 == 32, "R9 no relaunch", 32'(busy_cyc - b0), 32);
    rd_reg(4'd5, d); check(d == 32'h55, "R9 fg kept", d, 32'h55);
    cmp_mem("R9 memory");

    // R10: zero-sized rectangles
    r0 = req_cnt;
    wr_reg(4'd3, {3'b0, 13'd0, 16'd3});
    wr_reg(4'd0, go_word(5'd1, 1'b0));
    check(busy == 1'b0, "R10 zero width busy", 32'(busy), 0);
    wr_reg(4'd3, {3'b0, 13'd3, 16'd0});
    wr_reg(4'd0, go_word(5'd0, 1'b0));
    check(busy == 1'b0, "R10 zero height busy", 32'(busy), 0);
    repeat (2) @(negedge clk);
    check(req_cnt == r0, "R10 no access", 32'(req_cnt - r0), 0);
    cmp_mem("R10 memory");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule